// File: doc/BRIEF.md
# PCM FIFO Sample Unpacker

This block sits between a byte-wide circular audio buffer and the playback path. On every output-rate tick (nominally 48 kHz) it looks at the bytes waiting in a 32-entry buffer and turns them into one signed 16-bit left/right sample pair. A two-bit format code chooses 8-bit or 16-bit samples, and mono or stereo framing. It also reports how many bytes were taken, so that the owner of the buffer can move its read position at the same clock edge.

The buffer positions are free-running counters. The byte address is a position taken modulo the depth, and the fill level is the write position minus the read position. When the buffer holds fewer bytes than one frame needs, the tick yields silence and nothing is consumed. Between ticks the sample outputs keep their last value.

Top module: `pcm_fifo_unpacker`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, both sample outputs are zero. The byte count is zero whenever no tick is present.
- R2: Format code 2'b00 (mono, 8-bit): the byte at the read position, XORed with 0x80 and placed in bits 15:8 with zeros in bits 7:0, drives both left and right. One byte is consumed.
- R3: Format code 2'b01 (stereo, 8-bit): the byte at the read position becomes left and the next byte becomes right, each converted as in R2. Two bytes are consumed.
- R4: Format code 2'b10 (mono, 16-bit): the two bytes at the read position, least significant byte first, form one sample that drives both outputs. Two bytes are consumed.
- R5: Format code 2'b11 (stereo, 16-bit): bytes 0 and 1 form left and bytes 2 and 3 form right, each little-endian. Four bytes are consumed.
- R6: If the fill level (write minus read position, modulo 2^PTR_W) is below the frame size (1, 2, 2 or 4 bytes for codes 00, 01, 10, 11) when a tick arrives, both outputs become zero after that edge and the byte count is zero in that cycle.
- R7: In a cycle without a tick, the sample outputs do not change at the next edge and the byte count is zero.
- R8: Byte addresses wrap modulo 32, so a frame that starts near the end of the buffer takes its later bytes from index 0 upward. The positions themselves wrap modulo 2^PTR_W.
- R9: When a tick arrives with enough data, the byte count equals the frame size in that same cycle (combinational), and the new samples appear after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Output sample strobe, one cycle wide |
| fmt | input | 2 | Format code: bit 1 selects 16-bit samples, bit 0 selects stereo |
| fifo_bytes | input | DEPTH*8 | Buffer contents, byte i at bits [8i+7:8i] |
| wr_pos | input | PTR_W | Free-running write position |
| rd_pos | input | PTR_W | Free-running read position |
| sample_l | output | 16 | Left sample, signed |
| sample_r | output | 16 | Right sample, signed |
| rd_step | output | 3 | Bytes consumed this cycle; add it to the read position at the edge |

## Verification
A wrong fill-level calculation shows up at the first tick that meets a buffer holding exactly one byte less than a frame, or exactly a frame. The byte count is then wrong in that very cycle and the samples are wrong one edge later. A wrong lane index or a wrong wrap of the lane index corrupts the samples only when a frame straddles the end of the buffer, so the bench drives long runs that carry the read position across both the 32-byte boundary and the position-counter boundary. A bad hold path shows at the next edge after any cycle without a tick.

// File: rtl/pcmu_pkg.sv
`timescale 1ns/1ps
package pcmu_pkg;

    localparam int SAMPLE_W = 16;
    localparam int LANES    = 4;
    localparam int STEP_W   = 3;

    typedef enum logic [1:0] {
        FMT_MONO8    = 2'b00,
        FMT_STEREO8  = 2'b01,
        FMT_MONO16   = 2'b10,
        FMT_STEREO16 = 2'b11
    } pcm_fmt_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pcm_pair_t;

    typedef logic [LANES-1:0][7:0] lane_vec_t;

    // Frame size in bytes for each layout.
    function automatic logic [STEP_W-1:0] frame_bytes(input pcm_fmt_e f);
        case (f)
            FMT_MONO8:    return STEP_W'(1);
            FMT_STEREO8:  return STEP_W'(2);
            FMT_MONO16:   return STEP_W'(2);
            default:      return STEP_W'(4);
        endcase
    endfunction

    // Unsigned 8-bit to signed 16-bit: flip the sign bit, move to the top byte.
    function automatic logic [SAMPLE_W-1:0] widen_u8(input logic [7:0] b);
        return {b ^ 8'h80, 8'h00};
    endfunction

    // Little-endian pair of bytes.
    function automatic logic [SAMPLE_W-1:0] join_le(input logic [7:0] lo, input logic [7:0] hi);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/pcmu_level.sv
`timescale 1ns/1ps
module pcmu_level
    import pcmu_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic [PTR_W-1:0]  wr_pos,
    input  logic [PTR_W-1:0]  rd_pos,
    input  logic [STEP_W-1:0] need,
    output logic [PTR_W-1:0]  level,
    output logic              enough
);
    // Free-running positions: modular difference is the fill level.
    always_comb begin
        level  = wr_pos - rd_pos;
        enough = (level >= PTR_W'(need));
    end
endmodule

// File: rtl/pcmu_lane_fetch.sv
`timescale 1ns/1ps
module pcmu_lane_fetch
    import pcmu_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int PTR_W = 8
) (
    input  logic [DEPTH*8-1:0] fifo_bytes,
    input  logic [PTR_W-1:0]   rd_pos,
    output lane_vec_t          lanes
);
    localparam int ADDR_W = $clog2(DEPTH);

    // One byte mux per lane; lane i reads position rd_pos+i modulo DEPTH.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [PTR_W-1:0]  pos_i;
        logic [ADDR_W-1:0] idx_i;
        always_comb begin
            pos_i    = rd_pos + PTR_W'(i);
            idx_i    = pos_i[ADDR_W-1:0];
            lanes[i] = fifo_bytes[{idx_i, 3'b000} +: 8];
        end
    end
endmodule

// File: rtl/pcmu_assemble.sv
`timescale 1ns/1ps
module pcmu_assemble
    import pcmu_pkg::*;
(
    input  pcm_fmt_e  fmt,
    input  lane_vec_t lanes,
    output pcm_pair_t pair
);
    always_comb begin
        case (fmt)
            FMT_MONO8: begin
                pair.left  = widen_u8(lanes[0]);
                pair.right = widen_u8(lanes[0]);
            end
            FMT_STEREO8: begin
                pair.left  = widen_u8(lanes[0]);
                pair.right = widen_u8(lanes[1]);
            end
            FMT_MONO16: begin
                pair.left  = join_le(lanes[0], lanes[1]);
                pair.right = join_le(lanes[0], lanes[1]);
            end
            default: begin
                pair.left  = join_le(lanes[0], lanes[1]);
                pair.right = join_le(lanes[2], lanes[3]);
            end
        endcase
    end
endmodule

// File: rtl/pcm_fifo_unpacker.sv
`timescale 1ns/1ps
module pcm_fifo_unpacker
    import pcmu_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int PTR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [1:0]           fmt,
    input  logic [DEPTH*8-1:0]   fifo_bytes,
    input  logic [PTR_W-1:0]     wr_pos,
    input  logic [PTR_W-1:0]     rd_pos,
    output logic [SAMPLE_W-1:0]  sample_l,
    output logic [SAMPLE_W-1:0]  sample_r,
    output logic [STEP_W-1:0]    rd_step
);
    pcm_fmt_e          fmt_e;
    logic [STEP_W-1:0] need;
    logic [PTR_W-1:0]  level;
    logic              enough;
    lane_vec_t         lanes;
    pcm_pair_t         built;
    pcm_pair_t         out_q;

    always_comb begin
        fmt_e = pcm_fmt_e'(fmt);
        need  = frame_bytes(fmt_e);
    end

    pcmu_level #(.PTR_W(PTR_W)) u_level (
        .wr_pos (wr_pos),
        .rd_pos (rd_pos),
        .need   (need),
        .level  (level),
        .enough (enough)
    );

    pcmu_lane_fetch #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_fetch (
        .fifo_bytes (fifo_bytes),
        .rd_pos     (rd_pos),
        .lanes      (lanes)
    );

    pcmu_assemble u_asm (
        .fmt   (fmt_e),
        .lanes (lanes),
        .pair  (built)
    );

    // Consumption is reported in the tick cycle so the owner can move its pointer at the same edge.
    assign rd_step = (tick && enough) ? need : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (tick) begin
            out_q <= enough ? built : '0;
        end
    end

    assign sample_l = out_q.left;
    assign sample_r = out_q.right;

    logic unused_level;
    assign unused_level = ^level;
endmodule

// File: rtl/pcmu_checker.sv
`timescale 1ns/1ps
module pcmu_checker
    import pcmu_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int PTR_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                tick,
    input logic [1:0]          fmt,
    input logic [PTR_W-1:0]    wr_pos,
    input logic [PTR_W-1:0]    rd_pos,
    input logic [SAMPLE_W-1:0] sample_l,
    input logic [SAMPLE_W-1:0] sample_r,
    input logic [STEP_W-1:0]   rd_step
);
    logic [PTR_W-1:0]  fill;
    logic [STEP_W-1:0] frame;
    logic              short_buf;

    always_comb begin
        fill      = wr_pos - rd_pos;
        frame     = frame_bytes(pcm_fmt_e'(fmt));
        short_buf = fill < PTR_W'(frame);
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (sample_l == '0 && sample_r == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(sample_l) && $stable(sample_r)));

    assert_idle_step_R7: assert property (@(posedge clk) disable iff (rst)
        !tick |-> rd_step == '0);

    assert_short_silence_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && short_buf) |=> (sample_l == '0 && sample_r == '0));

    assert_short_nostep_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && short_buf) |-> rd_step == '0);

    // Mono layouts (R2 and R4) duplicate one sample onto both outputs.
    assert_mono_dup_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !fmt[0]) |=> sample_l == sample_r);

    assert_step_R9: assert property (@(posedge clk) disable iff (rst)
        (tick && !short_buf) |-> rd_step == frame);

    assert_step_shape_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(rd_step) <= 1);
endmodule

bind pcm_fifo_unpacker pcmu_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .fmt      (fmt),
    .wr_pos   (wr_pos),
    .rd_pos   (rd_pos),
    .sample_l (sample_l),
    .sample_r (sample_r),
    .rd_step  (rd_step)
);

// File: tb/pcm_fifo_unpacker_bench.sv
`timescale 1ns/1ps
module pcm_fifo_unpacker_bench;
    localparam int DEPTH = 32;
    localparam int PTR_W = 8;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 tick;
    logic [1:0]           fmt;
    logic [DEPTH*8-1:0]   fifo_bytes;
    logic [PTR_W-1:0]     wr_pos;
    logic [PTR_W-1:0]     rd_pos;
    logic [15:0]          sample_l;
    logic [15:0]          sample_r;
    logic [2:0]           rd_step;

    logic [7:0] mem [DEPTH];
    int wr_cnt;
    int rd_cnt;
    logic [15:0] exp_l;
    logic [15:0] exp_r;
    int n_checks;
    int n_fail;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) fifo_bytes[i*8 +: 8] = mem[i];
        wr_pos = wr_cnt[PTR_W-1:0];
        rd_pos = rd_cnt[PTR_W-1:0];
    end

    pcm_fifo_unpacker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_pcm_fifo_unpacker (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .fmt        (fmt),
        .fifo_bytes (fifo_bytes),
        .wr_pos     (wr_pos),
        .rd_pos     (rd_pos),
        .sample_l   (sample_l),
        .sample_r   (sample_r),
        .rd_step    (rd_step)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int frame_of(input logic [1:0] f);
        return (f == 2'b00) ? 1 : (f == 2'b11) ? 4 : 2;
    endfunction

    function automatic logic [7:0] peek(input int k);
        return mem[(rd_cnt + k) % DEPTH];
    endfunction

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            if (wr_cnt - rd_cnt < DEPTH) begin
                mem[wr_cnt % DEPTH] = 8'($urandom);
                wr_cnt++;
            end
        end
    endtask

    // One clock: drive at the falling edge, check the step, then the samples after the rising edge.
    task automatic cycle(input bit t, input logic [1:0] f, input int nwr);
        int need, lvl, step_exp;
        bit ok, wraps;
        string tag_s, tag_o;
        @(negedge clk);
        tick = t;
        fmt  = f;
        #1;
        need     = frame_of(f);
        lvl      = wr_cnt - rd_cnt;
        ok       = t && (lvl >= need);
        step_exp = ok ? need : 0;
        wraps    = ((rd_cnt % DEPTH) + need) > DEPTH;
        tag_s = !t ? "R7" : (!ok ? "R6" : "R9");
        if (!t) tag_o = "R7";
        else if (!ok) tag_o = "R6";
        else if (wraps) tag_o = "R8";
        else tag_o = (f == 2'b00) ? "R2" : (f == 2'b01) ? "R3" : (f == 2'b10) ? "R4" : "R5";
        check(tag_s, "rd_step", int'(rd_step), step_exp);
        if (t) begin
            if (!ok) begin
                exp_l = 16'h0; exp_r = 16'h0;
            end else begin
                case (f)
                    2'b00: begin exp_l = {peek(0) ^ 8'h80, 8'h00}; exp_r = exp_l; end
                    2'b01: begin exp_l = {peek(0) ^ 8'h80, 8'h00}; exp_r = {peek(1) ^ 8'h80, 8'h00}; end
                    2'b10: begin exp_l = {peek(1), peek(0)}; exp_r = exp_l; end
                    default: begin exp_l = {peek(1), peek(0)}; exp_r = {peek(3), peek(2)}; end
                endcase
            end
        end
        @(posedge clk);
        #1;
        rd_cnt += step_exp;
        tick = 1'b0;
        push(nwr);
        check(tag_o, "sample_l", int'(sample_l), int'(exp_l));
        check(tag_o, "sample_r", int'(sample_r), int'(exp_r));
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        n_checks = 0; n_fail = 0;
        wr_cnt = 0; rd_cnt = 0;
        exp_l = '0; exp_r = '0;
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
        rst = 1'b1; tick = 1'b0; fmt = 2'b00;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "sample_l in reset", int'(sample_l), 0);
        check("R1", "sample_r in reset", int'(sample_r), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "rd_step idle", int'(rd_step), 0);
        @(posedge clk); #1;
        check("R1", "sample_l after reset", int'(sample_l), 0);

        // Each layout with data present (R2..R5), with hold cycles between (R7).
        push(12);
        cycle(1, 2'b00, 0);
        cycle(0, 2'b11, 0);
        cycle(1, 2'b01, 0);
        cycle(1, 2'b10, 0);
        cycle(0, 2'b00, 3);
        cycle(1, 2'b11, 4);
        cycle(1, 2'b11, 0);

        // Fill level just below and exactly at the frame size (R6, R9).
        for (int f = 0; f < 4; f++) begin
            while (wr_cnt - rd_cnt > frame_of(2'(f)) - 1) cycle(1, 2'b00, 0);
            cycle(1, 2'(f), 0);
            cycle(0, 2'(f), 1);
            cycle(1, 2'(f), 0);
        end

        // Long mixed run: read position crosses the buffer end and the counter wrap (R8).
        for (int n = 0; n < 700; n++) begin
            cycle(($urandom % 10) < 7, 2'($urandom), int'($urandom % 5));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule